// File: doc/BRIEF.md
# Remote Delay and Fault Latch

This block decides when a switched-mode power supply is allowed to run. A host drives a remote request: high means "stay off", low means "run". The request is synchronised and then filtered by two separate delays. Going to the off state takes a short delay. Going to the run state takes a longer one, nominally three times as long. The filtered level is the delayed remote state, which other blocks also use. The supply-disable output is high whenever the delayed remote state is high or the fault latch is set.

Over-voltage flags (three rails plus one spare input) and under-voltage flags (three rails) set a sticky fault latch. After the supply is enabled, under-voltage flags are blanked for a programmable number of ticks so that the rails can ramp up. A fault that clears on its own never restarts the supply. Only a delayed remote-off state clears the latch, and the supply then runs again only once the remote request returns low and the run delay expires. All delays count pulses of a tick-enable input, so the time base is supplied from outside the block.

Top module: `psu_remote_guard`

## Requirements
- R1: Supply-disable `supply_off` is 1 whenever `remote_dly` is 1 or the fault latch is set, and 0 otherwise. A 1 on `remote_req` requests off and a 0 requests run.
- R2: When the synchronised remote request is 1 and `remote_dly` is 0, `remote_dly` becomes 1 at the clock edge of the OFF_TICKS-th tick pulse counted while the mismatch lasts.
- R3: When the synchronised remote request is 0 and `remote_dly` is 1, `remote_dly` becomes 0 at the clock edge of the ON_TICKS-th tick pulse counted while the mismatch lasts. With the defaults, ON_TICKS is three times OFF_TICKS.
- R4: If the synchronised request returns to the level of `remote_dly` before its delay expires, the count is discarded and `remote_dly` does not change.
- R5: Timers advance only on clock edges where `tick_en` is 1. `remote_dly` changes only at such an edge.
- R6: Any 1 bit of `ovp_flag` (bits 0 to 2 are rails, bit 3 is the spare input) sets the fault latch. The latch, and with it `supply_off`, stays set after the flag drops, for as long as `remote_dly` is 0.
- R7: After `remote_dly` falls, `uvp_flag` bits have no effect for BLANK_TICKS tick pulses. After that window, any 1 bit sets the fault latch.
- R8: A 1 on `remote_dly` clears the fault latch, and it takes precedence over a simultaneous set. The supply runs again only after `remote_req` returns to 0 and the run delay expires.
- R9: During and after reset, `remote_dly` is 1, the fault latch is clear, and the remote synchroniser stages hold 1, so an undriven request is treated as off. The flag synchroniser stages hold 0.
- R10: `supply_off` falls only at an edge where `remote_dly` also falls. Clearing a fault never enables the supply by itself.
- R11: `remote_req`, `ovp_flag` and `uvp_flag` each pass through SYNC_STAGES flip-flops before any logic uses them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle time-base pulse that advances all delay counters |
| remote_req | input | 1 | Host request, 1 = off, 0 = run |
| ovp_flag | input | OVP_N | Over-voltage flags, bit 3 is the spare protection input |
| uvp_flag | input | UVP_N | Under-voltage flags |
| supply_off | output | 1 | Supply-disable, 1 = power stage held off |
| remote_dly | output | 1 | Delayed remote state for neighbouring blocks |

## Verification
The bench goes after remote pulses shorter than either delay. A design that does not cancel the count would turn off or on after a glitch. It holds `tick_en` low for long stretches, which catches timers that run on the clock instead of on the tick. An under-voltage flag inside the blanking window must leave the supply running, and the same flag after the window must trip it. A fault that goes away must keep the supply off. A design that lets the latch self-clear, or that lets set win over the remote clear, would restart the supply early or never restart it. A long stretch of random requests, flags and tick rates is compared cycle by cycle against a behavioural model.

// File: rtl/rguard_pkg.sv
package rguard_pkg;

   // Level meaning of the remote request and the delayed state
   typedef enum logic {
      RG_RUN = 1'b0,
      RG_OFF = 1'b1
   } rg_level_e;

   function automatic int rg_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int rg_cnt_w(input int limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/rguard_sync.sv
module rguard_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("rguard_sync: W must be at least 1");
      end
      if (STAGES > 4) begin : g_bad_stages
         $error("rguard_sync: STAGES above 4 is not supported");
      end

      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) begin
                  stage_q[i] <= RST_VAL;
               end
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  stage_q[i] <= stage_q[i-1];
               end
            end
         end

         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rguard_delay.sv
module rguard_delay
   import rguard_pkg::*;
#(
   parameter int        RISE_TICKS = 8,
   parameter int        FALL_TICKS = 24,
   parameter rg_level_e RST_LEVEL  = RG_OFF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic din,
   output logic dout
);

   localparam int             CW        = rg_cnt_w(rg_max(RISE_TICKS, FALL_TICKS));
   localparam logic [CW-1:0]  RISE_LAST = CW'(RISE_TICKS - 1);
   localparam logic [CW-1:0]  FALL_LAST = CW'(FALL_TICKS - 1);

   generate
      if (RISE_TICKS < 1 || FALL_TICKS < 1) begin : g_bad_ticks
         $error("rguard_delay: both delays must be at least one tick");
      end
   endgenerate

   logic          level_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last_cnt;
   logic          expire;

   // The target depends on the direction of the pending change
   assign last_cnt = din ? RISE_LAST : FALL_LAST;
   assign expire   = tick_en && (cnt_q == last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= logic'(RST_LEVEL);
         cnt_q   <= '0;
      end else if (din == level_q) begin
         cnt_q   <= '0;
      end else if (expire) begin
         level_q <= din;
         cnt_q   <= '0;
      end else if (tick_en) begin
         cnt_q   <= cnt_q + CW'(1);
      end
   end

   assign dout = level_q;

endmodule

// File: rtl/rguard_blank.sv
module rguard_blank
   import rguard_pkg::*;
#(
   parameter int BLANK_TICKS = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic hold,
   output logic blank_on
);

   generate
      if (BLANK_TICKS < 0) begin : g_bad_blank
         $error("rguard_blank: BLANK_TICKS must not be negative");
      end

      if (BLANK_TICKS == 0) begin : g_none
         assign blank_on = 1'b0;
      end else begin : g_count
         localparam int            BW       = rg_cnt_w(BLANK_TICKS);
         localparam logic [BW-1:0] BLANK_END = BW'(BLANK_TICKS);

         logic [BW-1:0] elapsed_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               elapsed_q <= '0;
            end else if (hold) begin
               elapsed_q <= '0;
            end else if (tick_en && (elapsed_q != BLANK_END)) begin
               elapsed_q <= elapsed_q + BW'(1);
            end
         end

         assign blank_on = (elapsed_q != BLANK_END);
      end
   endgenerate

endmodule

// File: rtl/rguard_latch.sv
module rguard_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (clr) begin
         q <= 1'b0;
      end else if (set) begin
         q <= 1'b1;
      end
   end

endmodule

// File: rtl/psu_remote_guard.sv
module psu_remote_guard
   import rguard_pkg::*;
#(
   parameter int OVP_N       = 4,
   parameter int UVP_N       = 3,
   parameter int SYNC_STAGES = 2,
   parameter int OFF_TICKS   = 8,
   parameter int ON_TICKS    = 24,
   parameter int BLANK_TICKS = 250
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             remote_req,
   input  logic [OVP_N-1:0] ovp_flag,
   input  logic [UVP_N-1:0] uvp_flag,
   output logic             supply_off,
   output logic             remote_dly
);

   localparam int FLAG_W = OVP_N + UVP_N;

   generate
      if (OVP_N < 1 || UVP_N < 1) begin : g_bad_flags
         $error("psu_remote_guard: flag widths must be at least 1");
      end
   endgenerate

   logic              remote_s;
   logic [FLAG_W-1:0] flags_s;
   logic [OVP_N-1:0]  ovp_s;
   logic [UVP_N-1:0]  uvp_s;
   logic              blank_on;
   logic              fault_set;
   logic              fault_q;

   // Remote stages preset to the off level
   rguard_sync #(
      .W       (1),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) i_sync_remote (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (remote_req),
      .q     (remote_s)
   );

   rguard_sync #(
      .W       (FLAG_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ('0)
   ) i_sync_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ovp_flag, uvp_flag}),
      .q     (flags_s)
   );

   assign ovp_s = flags_s[FLAG_W-1:UVP_N];
   assign uvp_s = flags_s[UVP_N-1:0];

   rguard_delay #(
      .RISE_TICKS (OFF_TICKS),
      .FALL_TICKS (ON_TICKS),
      .RST_LEVEL  (RG_OFF)
   ) i_delay (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .din     (remote_s),
      .dout    (remote_dly)
   );

   rguard_blank #(
      .BLANK_TICKS (BLANK_TICKS)
   ) i_blank (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .hold     (remote_dly),
      .blank_on (blank_on)
   );

   assign fault_set = (|ovp_s) || ((|uvp_s) && !blank_on);

   rguard_latch i_fault (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (fault_set),
      .clr   (remote_dly),
      .q     (fault_q)
   );

   assign supply_off = remote_dly | fault_q;

endmodule

// File: rtl/psu_remote_guard_chk.sv
module psu_remote_guard_chk #(
   parameter int OVP_N = 4,
   parameter int UVP_N = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             remote_dly,
   input logic             supply_off,
   input logic [OVP_N-1:0] ovp_s,
   input logic [UVP_N-1:0] uvp_s,
   input logic             blank_on,
   input logic             fault_q
);

   assert_dly_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(remote_dly) |-> $past(tick_en));

   assert_fault_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_q) |-> $past((|ovp_s) || (|uvp_s)));

   assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q && !remote_dly) |=> fault_q);

   assert_uvp_blanked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_on && (ovp_s == '0) && !fault_q) |=> !fault_q);

   assert_remote_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      remote_dly |=> !fault_q);

   assert_enable_via_remote_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(supply_off) |-> $fell(remote_dly));

endmodule

bind psu_remote_guard psu_remote_guard_chk #(
   .OVP_N (OVP_N),
   .UVP_N (UVP_N)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_en    (tick_en),
   .remote_dly (remote_dly),
   .supply_off (supply_off),
   .ovp_s      (ovp_s),
   .uvp_s      (uvp_s),
   .blank_on   (blank_on),
   .fault_q    (fault_q)
);

// File: tb/test_psu_remote_guard.sv
module test_psu_remote_guard;

   localparam int SYNC  = 2;
   localparam int OFF_T = 2;
   localparam int ON_T  = 6;
   localparam int BLANK = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       remote_req = 1'b1;
   logic [3:0] ovp_flag = '0;
   logic [2:0] uvp_flag = '0;
   logic       supply_off;
   logic       remote_dly;

   always #10 clk = ~clk;

   psu_remote_guard #(
      .OVP_N       (4),
      .UVP_N       (3),
      .SYNC_STAGES (SYNC),
      .OFF_TICKS   (OFF_T),
      .ON_TICKS    (ON_T),
      .BLANK_TICKS (BLANK)
   ) i_psu_remote_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .remote_req (remote_req),
      .ovp_flag   (ovp_flag),
      .uvp_flag   (uvp_flag),
      .supply_off (supply_off),
      .remote_dly (remote_dly)
   );

   // Behavioural reference model
   logic [7:0] pipe_q[$];
   logic       m_dly;
   logic       m_fault;
   int         m_cnt;
   int         m_blank;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q.delete();
         for (int i = 0; i < SYNC; i++) pipe_q.push_back(8'b1000_0000);
         m_dly = 1'b1; m_fault = 1'b0; m_cnt = 0; m_blank = 0;
      end else begin
         logic [7:0] s;
         logic       n_dly, n_fault, s_rem;
         int         n_cnt, n_blank, lim;
         s = pipe_q.pop_front();
         pipe_q.push_back({remote_req, ovp_flag, uvp_flag});
         s_rem = s[7];
         if (m_dly) n_fault = 1'b0;
         else if ((s[6:3] != 0) || ((s[2:0] != 0) && (m_blank >= BLANK))) n_fault = 1'b1;
         else n_fault = m_fault;
         if (m_dly) n_blank = 0;
         else if (tick_en && m_blank < BLANK) n_blank = m_blank + 1;
         else n_blank = m_blank;
         n_dly = m_dly;
         n_cnt = m_cnt;
         if (s_rem == m_dly) n_cnt = 0;
         else if (tick_en) begin
            lim = s_rem ? OFF_T : ON_T;
            if (m_cnt + 1 == lim) begin n_dly = s_rem; n_cnt = 0; end
            else n_cnt = m_cnt + 1;
         end
         m_dly = n_dly; m_fault = n_fault; m_cnt = n_cnt; m_blank = n_blank;
      end
   end

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R9";
   int    tick_div = 1;
   int    tick_ph = 0;
   logic  tick_hold = 1'b0;
   bit    done = 1'b0;

   task automatic compare_now();
      n_cmp++;
      if (supply_off !== (m_dly | m_fault) || remote_dly !== m_dly) begin
         n_bad++;
         $display("FAIL %s: supply_off=%b remote_dly=%b expected %b %b at %0t",
                  cur_req, supply_off, remote_dly, m_dly | m_fault, m_dly, $time);
      end
   endtask

   task automatic expect_bit(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) begin
         @(negedge clk);
         compare_now();
         tick_en = tick_hold ? 1'b0 : ((tick_ph % tick_div) == 0);
         tick_ph++;
      end
   endtask

   always @(posedge clk) begin
      if (!done && $time > 64'd4000000) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R9 reset state
      repeat (3) @(negedge clk);
      expect_bit("R9 remote_dly in reset", remote_dly, 1'b1);
      expect_bit("R9 supply_off in reset", supply_off, 1'b1);
      rst_n = 1'b1;
      remote_req = 1'b0;
      cyc(4);
      expect_bit("R9 still off during run delay", supply_off, 1'b1);

      // R1 R3 R11: run request with ticks every cycle
      cur_req = "R3";
      cyc(16);
      expect_bit("R1 supply runs", supply_off, 1'b0);

      // R2: off delay, SYNC stages then OFF_T ticks
      cur_req = "R2";
      remote_req = 1'b1;
      cyc(2);
      expect_bit("R2 not yet off", remote_dly, 1'b0);
      cyc(3);
      expect_bit("R2 off after delay", remote_dly, 1'b1);
      remote_req = 1'b0;
      cyc(20);

      // R4: short pulses on both sides are cancelled
      cur_req = "R4";
      remote_req = 1'b1;
      cyc(1);
      remote_req = 1'b0;
      cyc(10);
      expect_bit("R4 off pulse ignored", remote_dly, 1'b0);
      remote_req = 1'b1;
      cyc(10);
      remote_req = 1'b0;
      cyc(3);
      remote_req = 1'b1;
      cyc(15);
      expect_bit("R4 run pulse ignored", remote_dly, 1'b1);

      // R5: no ticks, no progress
      cur_req = "R5";
      tick_hold = 1'b1;
      remote_req = 1'b0;
      cyc(40);
      expect_bit("R5 frozen without tick", remote_dly, 1'b1);
      tick_hold = 1'b0;
      tick_div = 3;
      cyc(40);
      expect_bit("R3 runs with slow tick", remote_dly, 1'b0);
      tick_div = 1;

      // R7: uvp blanked right after enable, then trips
      cur_req = "R7";
      remote_req = 1'b1;
      cyc(10);
      remote_req = 1'b0;
      cyc(12);
      uvp_flag = 3'b001;
      cyc(4);
      uvp_flag = 3'b000;
      cyc(3);
      expect_bit("R7 uvp inside window ignored", supply_off, 1'b0);
      cyc(20);
      uvp_flag = 3'b100;
      cyc(1);
      uvp_flag = 3'b000;
      cyc(5);
      expect_bit("R7 uvp after window trips", supply_off, 1'b1);
      cyc(10);
      expect_bit("R6 fault stays after flag drops", supply_off, 1'b1);

      // R8: remote cycle clears; held ovp loses to clear
      cur_req = "R8";
      remote_req = 1'b1;
      ovp_flag = 4'b0001;
      cyc(10);
      ovp_flag = 4'b0000;
      remote_req = 1'b0;
      cyc(6);
      expect_bit("R8 still off during run delay", supply_off, 1'b1);
      cyc(15);
      expect_bit("R8 runs after remote cycle", supply_off, 1'b0);

      // R6: spare over-voltage input
      cur_req = "R6";
      ovp_flag = 4'b1000;
      cyc(1);
      ovp_flag = 4'b0000;
      cyc(5);
      expect_bit("R6 spare ovp trips", supply_off, 1'b1);
      expect_bit("R10 remote state untouched", remote_dly, 1'b0);
      remote_req = 1'b1;
      cyc(10);
      remote_req = 1'b0;
      cyc(20);
      expect_bit("R10 restart through remote", supply_off, 1'b0);

      // Random traffic compared every cycle
      cur_req = "R1";
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(39) == 0) remote_req = ~remote_req;
         ovp_flag = ($urandom_range(199) == 0) ? 4'(1 << $urandom_range(3)) : 4'b0000;
         uvp_flag = ($urandom_range(99) == 0) ? 3'(1 << $urandom_range(2)) : 3'b000;
         if ($urandom_range(199) == 0) tick_div = $urandom_range(1, 3);
         cyc(1);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule